// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block sits next to a 32-bit processor core and carries out the hardware part of entering a handler. When the core reports an instruction boundary, the sequencer decides whether to take an event. The candidates are an exception raised by the core, a fast interrupt and a normal prioritised interrupt. Once an event is taken, the sequencer captures the current status word and return address and switches the stack. It then produces the handler address and the updated status and stack values, which the core loads in a single commit cycle.

There are two entry paths. A fast interrupt keeps its return state in a pair of backup registers and jumps through a dedicated fast-vector register, so it never touches memory. A normal interrupt or an exception pushes the status word and the return PC onto the interrupt stack through a 32-bit valid/ready memory port, then reads a handler address from a vector table. Exceptions with small numbers use a fixed table near the top of the address space. Trap numbers and normal interrupts index a table whose base the core supplies. Only interrupts are acknowledged to the requester.

Top module: `irq_entry_seq`

## Requirements
- R1: Status word layout: bit 16 is interrupt enable (IE), bit 17 selects the user stack (US), bit 20 is the processor mode bit (PM), bits 27:24 are the priority level (IPL), and bits 3:0 are condition flags. A normal interrupt is taken only when IE is 1 and IPL is strictly less than `nrm_lvl`.
- R2: A fast interrupt is taken only when IE is 1 and IPL is not 15.
- R3: When several events qualify at once, an exception wins over a fast interrupt, and a fast interrupt wins over a normal one. An exception does not depend on IE or IPL.
- R4: Events are sampled only in a cycle where `insn_boundary` is 1 and the sequencer is idle. Requests, vector number and level that change while an entry is running have no effect on that entry.
- R5: Fast entry makes no memory access. It sets `save_we`, `save_pc` = return PC and `save_stat` = the status word as sampled, with `new_pc` = `fast_vec` and the IPL field of `new_stat` = 15.
- R6: Normal and exception entry write the sampled status word at base-4 and then the return PC at base-8, in that order. Base is the interrupt stack pointer after the switch of R9. These writes are followed by one 32-bit read of the handler address.
- R7: For a normal interrupt the handler address is read from `tbl_base + 4*nrm_vec`, and the IPL field of `new_stat` becomes the `nrm_lvl` sampled at acceptance.
- R8: For an exception code below 0x100 the handler address is read from 0xFFFFFFC0 + 4*code, modulo 2^32. For codes 0x100 to 0x1FF it is read from `tbl_base` + 4*(code mod 256). The IPL is left unchanged.
- R9: If US is 1, `new_usr_sp` takes `cur_r0` and the base stays at `cur_irq_sp`. Otherwise `new_usr_sp` = `cur_usr_sp` and the base is `cur_r0`. `new_irq_sp` is base-8 for stacked entries and base for fast entry, and `new_r0` equals `new_irq_sp`.
- R10: In `new_stat`, IE, US and PM are cleared and all other bits keep their sampled value, apart from the IPL of R5/R7. `sleep_clr` pulses together with `done`.
- R11: In the commit cycle of an interrupt, `ack_valid` pulses. `ack_fast` tells the fast interrupt (then `ack_num` = 0) from a normal one (then `ack_num` = the accepted vector). Exceptions produce no acknowledge.
- R12: `busy` is 1 from the cycle after acceptance through the commit cycle. `mem_valid` is only raised while busy, and a request waiting for `mem_ready` keeps its address and direction.
- R13: While and after reset, `busy`, `mem_valid`, `done` and `ack_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| exc_req | input | 1 | Exception or trap pending |
| exc_code | input | 9 | Exception or trap number |
| fst_req | input | 1 | Fast interrupt pending |
| nrm_req | input | 1 | Normal interrupt pending |
| nrm_vec | input | 8 | Normal interrupt vector number |
| nrm_lvl | input | 4 | Normal interrupt priority level |
| cur_stat | input | 32 | Current status word |
| cur_pc | input | 32 | Return PC |
| cur_r0 | input | 32 | Current general register 0 (active stack pointer) |
| cur_usr_sp | input | 32 | Saved user stack pointer |
| cur_irq_sp | input | 32 | Saved interrupt stack pointer |
| tbl_base | input | 32 | Relocatable vector table base |
| fast_vec | input | 32 | Fast interrupt handler address |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory request accepted / read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Commit strobe for all new_* and save_* values |
| new_pc | output | 32 | Handler address |
| new_stat | output | 32 | Updated status word |
| new_r0 | output | 32 | New register 0 |
| new_usr_sp | output | 32 | New user stack pointer |
| new_irq_sp | output | 32 | New interrupt stack pointer |
| save_we | output | 1 | Load the backup registers |
| save_pc | output | 32 | Backup PC value |
| save_stat | output | 32 | Backup status value |
| sleep_clr | output | 1 | Leave any sleep state |
| ack_valid | output | 1 | Interrupt acknowledge pulse |
| ack_fast | output | 1 | Acknowledge is for the fast interrupt |
| ack_num | output | 8 | Acknowledged vector number |

## Verification
The protocol assertions assume the memory side raises `mem_ready` only while `mem_valid` is 1 and drops it again after each accepted beat. The bench responder raises it from the falling edge, only for a pending request, after a programmed number of wait cycles. The assertion linking the start of `busy` to a boundary relies on reset holding the sequencer idle for at least one edge, and the bench starts every run that way. Request and status inputs are assumed to be free-running levels. The bench keeps them steady across each acceptance edge, and in one test it changes them on purpose mid-entry to probe R4.

// File: rtl/irq_entry_pkg.sv
`timescale 1ns/1ps
package irq_entry_pkg;

    localparam int XLEN  = 32;
    localparam int IPL_W = 4;
    localparam int VEC_W = 8;
    localparam int EXC_W = 9;

    // status word field positions
    localparam int ST_IE     = 16;
    localparam int ST_US     = 17;
    localparam int ST_PM     = 20;
    localparam int ST_IPL_LO = 24;

    localparam logic [IPL_W-1:0] IPL_MAX   = '1;
    localparam logic [XLEN-1:0]  FIXED_TBL = 32'hFFFF_FFC0;
    localparam logic [XLEN-1:0]  WORD_STEP = XLEN'(XLEN / 8);

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_FAST = 2'd2,
        EV_NORM = 2'd3
    } ev_kind_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_PUSH_ST = 3'd1,
        S_PUSH_PC = 3'd2,
        S_FETCH   = 3'd3,
        S_COMMIT  = 3'd4
    } seq_st_e;

    typedef struct packed {
        ev_kind_e           kind;
        logic [VEC_W-1:0]   vec;
        logic [IPL_W-1:0]   lvl;
        logic [XLEN-1:0]    saved_st;
        logic [XLEN-1:0]    ret_pc;
        logic [XLEN-1:0]    usp_n;
        logic [XLEN-1:0]    sp_base;
        logic [XLEN-1:0]    vaddr;
    } entry_ctx_t;

    function automatic logic [IPL_W-1:0] st_ipl(input logic [XLEN-1:0] st);
        return st[ST_IPL_LO +: IPL_W];
    endfunction

    // status word handed back to the core after entry
    function automatic logic [XLEN-1:0] entry_status(input logic [XLEN-1:0] st,
                                                     input ev_kind_e k,
                                                     input logic [IPL_W-1:0] lvl);
        logic [XLEN-1:0] r;
        r        = st;
        r[ST_IE] = 1'b0;
        r[ST_US] = 1'b0;
        r[ST_PM] = 1'b0;
        if (k == EV_FAST)
            r[ST_IPL_LO +: IPL_W] = IPL_MAX;
        else if (k == EV_NORM)
            r[ST_IPL_LO +: IPL_W] = lvl;
        return r;
    endfunction

endpackage

// File: rtl/irq_entry_arb.sv
`timescale 1ns/1ps
module irq_entry_arb
    import irq_entry_pkg::*;
(
    input  logic             sample,
    input  logic             exc_req,
    input  logic             fst_req,
    input  logic             nrm_req,
    input  logic [IPL_W-1:0] nrm_lvl,
    input  logic             ie,
    input  logic [IPL_W-1:0] ipl,
    output ev_kind_e         kind
);
    logic fst_ok;
    logic nrm_ok;

    assign fst_ok = fst_req && ie && (ipl != IPL_MAX);
    assign nrm_ok = nrm_req && ie && (ipl < nrm_lvl);

    always_comb begin
        kind = EV_NONE;
        if (sample) begin
            if (exc_req)
                kind = EV_EXC;
            else if (fst_ok)
                kind = EV_FAST;
            else if (nrm_ok)
                kind = EV_NORM;
        end
    end
endmodule

// File: rtl/irq_entry_vec.sv
`timescale 1ns/1ps
module irq_entry_vec
    import irq_entry_pkg::*;
(
    input  ev_kind_e          kind,
    input  logic [EXC_W-1:0]  code,
    input  logic [VEC_W-1:0]  vec,
    input  logic [XLEN-1:0]   tbl_base,
    output logic [XLEN-1:0]   vaddr
);
    localparam int PAD_W = XLEN - VEC_W - 2;

    logic              trap;
    logic [XLEN-1:0]   code_off;
    logic [XLEN-1:0]   vec_off;

    generate
        if (EXC_W > VEC_W) begin : g_trap_range
            assign trap = |code[EXC_W-1:VEC_W];
        end else begin : g_no_trap_range
            assign trap = 1'b0;
        end
    endgenerate

    assign code_off = {{PAD_W{1'b0}}, code[VEC_W-1:0], 2'b00};
    assign vec_off  = {{PAD_W{1'b0}}, vec, 2'b00};

    always_comb begin
        if (kind == EV_NORM)
            vaddr = tbl_base + vec_off;
        else if (trap)
            vaddr = tbl_base + code_off;
        else
            vaddr = FIXED_TBL + code_off;
    end
endmodule

// File: rtl/irq_entry_stk.sv
`timescale 1ns/1ps
module irq_entry_stk
    import irq_entry_pkg::*;
(
    input  logic             us,
    input  logic [XLEN-1:0]  r0,
    input  logic [XLEN-1:0]  usr_sp,
    input  logic [XLEN-1:0]  irq_sp,
    output logic [XLEN-1:0]  usp_n,
    output logic [XLEN-1:0]  sp_base
);
    // R0 holds the live pointer of whichever stack is active
    always_comb begin
        if (us) begin
            usp_n   = r0;
            sp_base = irq_sp;
        end else begin
            usp_n   = usr_sp;
            sp_base = r0;
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_boundary,
    input  logic              exc_req,
    input  logic [8:0]        exc_code,
    input  logic              fst_req,
    input  logic              nrm_req,
    input  logic [7:0]        nrm_vec,
    input  logic [3:0]        nrm_lvl,
    input  logic [31:0]       cur_stat,
    input  logic [31:0]       cur_pc,
    input  logic [31:0]       cur_r0,
    input  logic [31:0]       cur_usr_sp,
    input  logic [31:0]       cur_irq_sp,
    input  logic [31:0]       tbl_base,
    input  logic [31:0]       fast_vec,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       new_pc,
    output logic [31:0]       new_stat,
    output logic [31:0]       new_r0,
    output logic [31:0]       new_usr_sp,
    output logic [31:0]       new_irq_sp,
    output logic              save_we,
    output logic [31:0]       save_pc,
    output logic [31:0]       save_stat,
    output logic              sleep_clr,
    output logic              ack_valid,
    output logic              ack_fast,
    output logic [7:0]        ack_num
);
    seq_st_e     st_q, st_n;
    entry_ctx_t  ctx_q, ctx_d;
    ev_kind_e    kind;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] vaddr_d;
    logic [XLEN-1:0] usp_d;
    logic [XLEN-1:0] base_d;
    logic            idle;
    logic            take;

    assign idle = (st_q == S_IDLE);

    irq_entry_arb u_arb (
        .sample  (insn_boundary && idle),
        .exc_req (exc_req),
        .fst_req (fst_req),
        .nrm_req (nrm_req),
        .nrm_lvl (nrm_lvl),
        .ie      (cur_stat[ST_IE]),
        .ipl     (st_ipl(cur_stat)),
        .kind    (kind)
    );

    irq_entry_vec u_vec (
        .kind     (kind),
        .code     (exc_code),
        .vec      (nrm_vec),
        .tbl_base (tbl_base),
        .vaddr    (vaddr_d)
    );

    irq_entry_stk u_stk (
        .us      (cur_stat[ST_US]),
        .r0      (cur_r0),
        .usr_sp  (cur_usr_sp),
        .irq_sp  (cur_irq_sp),
        .usp_n   (usp_d),
        .sp_base (base_d)
    );

    assign take = (kind != EV_NONE);

    always_comb begin
        ctx_d.kind     = kind;
        ctx_d.vec      = nrm_vec;
        ctx_d.lvl      = nrm_lvl;
        ctx_d.saved_st = cur_stat;
        ctx_d.ret_pc   = cur_pc;
        ctx_d.usp_n    = usp_d;
        ctx_d.sp_base  = base_d;
        ctx_d.vaddr    = vaddr_d;
    end

    // sequencing and memory port
    always_comb begin
        st_n      = st_q;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            S_IDLE: begin
                if (take)
                    st_n = (kind == EV_FAST) ? S_COMMIT : S_PUSH_ST;
            end
            S_PUSH_ST: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = ctx_q.sp_base - WORD_STEP;
                mem_wdata = ctx_q.saved_st;
                if (mem_ready)
                    st_n = S_PUSH_PC;
            end
            S_PUSH_PC: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = ctx_q.sp_base - (WORD_STEP << 1);
                mem_wdata = ctx_q.ret_pc;
                if (mem_ready)
                    st_n = S_FETCH;
            end
            S_FETCH: begin
                mem_valid = 1'b1;
                mem_addr  = ctx_q.vaddr;
                if (mem_ready)
                    st_n = S_COMMIT;
            end
            S_COMMIT: st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            ctx_q <= '0;
            pc_q  <= '0;
        end else begin
            st_q <= st_n;
            if (idle && take) begin
                ctx_q <= ctx_d;
                if (kind == EV_FAST)
                    pc_q <= fast_vec;
            end
            if (st_q == S_FETCH && mem_ready)
                pc_q <= mem_rdata;
        end
    end

    // commit outputs
    logic is_fast_q;
    assign is_fast_q  = (ctx_q.kind == EV_FAST);

    assign busy       = !idle;
    assign done       = (st_q == S_COMMIT);
    assign new_pc     = pc_q;
    assign new_stat   = entry_status(ctx_q.saved_st, ctx_q.kind, ctx_q.lvl);
    assign new_irq_sp = is_fast_q ? ctx_q.sp_base : ctx_q.sp_base - (WORD_STEP << 1);
    assign new_r0     = new_irq_sp;
    assign new_usr_sp = ctx_q.usp_n;
    assign save_we    = done && is_fast_q;
    assign save_pc    = ctx_q.ret_pc;
    assign save_stat  = ctx_q.saved_st;
    assign sleep_clr  = done;
    assign ack_valid  = done && (ctx_q.kind == EV_FAST || ctx_q.kind == EV_NORM);
    assign ack_fast   = done && is_fast_q;
    assign ack_num    = (ctx_q.kind == EV_NORM) ? ctx_q.vec : '0;

    // checks on the sequence
    assert_busy_after_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(insn_boundary));

    assert_fast_no_mem_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && is_fast_q) |-> !mem_valid);

    assert_read_after_pushes_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write && !$past(mem_valid && !mem_write)) |->
            $past(mem_valid && mem_write));

    assert_flags_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!new_stat[ST_IE] && !new_stat[ST_US] && !new_stat[ST_PM]));

    assert_ack_only_commit_R11: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> done);

    assert_mem_in_busy_R12: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> busy);

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

    typedef struct packed {
        logic        exc;
        logic [8:0]  code;
        logic        fst;
        logic        nrm;
        logic [7:0]  nv;
        logic [3:0]  nl;
        logic [31:0] st;
        logic [3:0]  lat;
        logic        pri;
        logic [1:0]  ek;   // 0 none, 1 exception, 2 fast, 3 normal
    } vec_t;

    localparam logic [31:0] TB_BASE = 32'h0008_0000;
    localparam logic [31:0] FVEC    = 32'h0000_F000;
    localparam int NV = 13;

    localparam vec_t VT [NV] = '{
        '{1'b0, 9'h000, 1'b0, 1'b1, 8'h40, 4'd5,  32'h0311_000B, 4'd0, 1'b0, 2'd3},
        '{1'b0, 9'h000, 1'b0, 1'b1, 8'h41, 4'd5,  32'h0501_0000, 4'd0, 1'b0, 2'd0},
        '{1'b0, 9'h000, 1'b0, 1'b1, 8'h42, 4'd9,  32'h0300_0005, 4'd0, 1'b0, 2'd0},
        '{1'b0, 9'h000, 1'b1, 1'b0, 8'h00, 4'd0,  32'h0E03_0002, 4'd0, 1'b0, 2'd2},
        '{1'b0, 9'h000, 1'b1, 1'b0, 8'h00, 4'd0,  32'h0F01_0000, 4'd0, 1'b0, 2'd0},
        '{1'b0, 9'h000, 1'b1, 1'b1, 8'h21, 4'd7,  32'h0201_0001, 4'd0, 1'b1, 2'd2},
        '{1'b1, 9'h017, 1'b0, 1'b0, 8'h00, 4'd0,  32'h0700_0004, 4'd2, 1'b0, 2'd1},
        '{1'b1, 9'h1A3, 1'b0, 1'b0, 8'h00, 4'd0,  32'h0113_0003, 4'd1, 1'b0, 2'd1},
        '{1'b1, 9'h014, 1'b1, 1'b1, 8'h05, 4'd3,  32'h0001_0000, 4'd0, 1'b1, 2'd1},
        '{1'b0, 9'h000, 1'b0, 1'b1, 8'hFF, 4'd15, 32'h0E03_000F, 4'd1, 1'b0, 2'd3},
        '{1'b1, 9'h0FF, 1'b0, 1'b0, 8'h00, 4'd0,  32'h0A00_0000, 4'd0, 1'b0, 2'd1},
        '{1'b0, 9'h000, 1'b1, 1'b0, 8'h00, 4'd0,  32'h0000_0008, 4'd0, 1'b0, 2'd0},
        '{1'b0, 9'h000, 1'b0, 1'b1, 8'h00, 4'd1,  32'h0001_0000, 4'd0, 1'b0, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_boundary, exc_req, fst_req, nrm_req;
    logic [8:0]  exc_code;
    logic [7:0]  nrm_vec;
    logic [3:0]  nrm_lvl;
    logic [31:0] cur_stat, cur_pc, cur_r0, cur_usr_sp, cur_irq_sp, tbl_base, fast_vec;
    logic        mem_valid, mem_write, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, save_we, sleep_clr, ack_valid, ack_fast;
    logic [31:0] new_pc, new_stat, new_r0, new_usr_sp, new_irq_sp, save_pc, save_stat;
    logic [7:0]  ack_num;

    always #4 clk = ~clk;

    irq_entry_seq dut (
        .clk(clk), .rst(rst), .insn_boundary(insn_boundary),
        .exc_req(exc_req), .exc_code(exc_code), .fst_req(fst_req),
        .nrm_req(nrm_req), .nrm_vec(nrm_vec), .nrm_lvl(nrm_lvl),
        .cur_stat(cur_stat), .cur_pc(cur_pc), .cur_r0(cur_r0),
        .cur_usr_sp(cur_usr_sp), .cur_irq_sp(cur_irq_sp),
        .tbl_base(tbl_base), .fast_vec(fast_vec),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .new_pc(new_pc), .new_stat(new_stat),
        .new_r0(new_r0), .new_usr_sp(new_usr_sp), .new_irq_sp(new_irq_sp),
        .save_we(save_we), .save_pc(save_pc), .save_stat(save_stat),
        .sleep_clr(sleep_clr), .ack_valid(ack_valid), .ack_fast(ack_fast),
        .ack_num(ack_num)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int          cur_lat = 0;
    int          wcnt = 0;
    int          log_n = 0;
    logic [31:0] log_a [8];
    logic [31:0] log_d [8];
    logic        log_w [8];

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        return a ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory responder: ready raised from the falling edge after cur_lat waits
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                wcnt = 0;
            end
            if (mem_valid) begin
                if (wcnt >= cur_lat) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem_model(mem_addr);
                    if (log_n < 8) begin
                        log_a[log_n] = mem_addr;
                        log_d[log_n] = mem_wdata;
                        log_w[log_n] = mem_write;
                    end
                    log_n++;
                end else begin
                    wcnt++;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_done(input string tag);
        int t;
        t = 0;
        while (!done && t < 64) begin
            @(negedge clk);
            t++;
        end
        chk(tag, "entry reaches commit", {31'd0, done}, 32'd1);
    endtask

    initial begin
        rst = 1'b1;
        insn_boundary = 0; exc_req = 0; fst_req = 0; nrm_req = 0;
        exc_code = '0; nrm_vec = '0; nrm_lvl = '0;
        cur_stat = '0; cur_pc = '0; cur_r0 = '0;
        cur_usr_sp = 32'h0000_6000; cur_irq_sp = 32'h0000_5000;
        tbl_base = TB_BASE; fast_vec = FVEC;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "busy in reset", {31'd0, busy}, 32'd0);
        chk("R13", "mem_valid in reset", {31'd0, mem_valid}, 32'd0);
        chk("R13", "done/ack in reset", {30'd0, done, ack_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t        v;
            logic [31:0] pc_i, r0_i, base, eusp, eisp, vad, epc, est;
            string       acc;
            v    = VT[i];
            pc_i = 32'h0000_1230 + 32'(i * 16);
            r0_i = 32'h0000_7000 + 32'(i * 256);
            base = v.st[17] ? 32'h0000_5000 : r0_i;
            eusp = v.st[17] ? r0_i : 32'h0000_6000;
            eisp = (v.ek == 2'd2) ? base : base - 32'd8;
            if (v.ek == 2'd3)
                vad = TB_BASE + {22'd0, v.nv, 2'b00};
            else if (v.code[8])
                vad = TB_BASE + {22'd0, v.code[7:0], 2'b00};
            else
                vad = 32'hFFFF_FFC0 + {22'd0, v.code[7:0], 2'b00};
            epc = (v.ek == 2'd2) ? FVEC : mem_model(vad);
            est = v.st & ~32'h0013_0000;
            if (v.ek == 2'd2) est[27:24] = 4'hF;
            if (v.ek == 2'd3) est[27:24] = v.nl;
            acc = v.pri ? "R3" : (v.exc ? "R8" : (v.fst ? "R2" : "R1"));

            cur_stat = v.st; cur_pc = pc_i; cur_r0 = r0_i;
            exc_req = v.exc; exc_code = v.code; fst_req = v.fst;
            nrm_req = v.nrm; nrm_vec = v.nv; nrm_lvl = v.nl;
            cur_lat = int'(v.lat);
            log_n = 0;
            insn_boundary = 1'b1;
            @(negedge clk);
            insn_boundary = 1'b0;

            if (v.ek == 2'd0) begin
                logic seen;
                seen = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    seen = seen | busy | mem_valid | done;
                    @(negedge clk);
                end
                chk(acc, $sformatf("vector %0d not taken", i), {31'd0, seen}, 32'd0);
            end else begin
                wait_done(acc);
                chk("R12", $sformatf("vector %0d busy at commit", i), {31'd0, busy}, 32'd1);
                chk(acc, $sformatf("vector %0d new_pc", i), new_pc, epc);
                chk((v.ek == 2'd3) ? "R7" : "R10", $sformatf("vector %0d new_stat", i), new_stat, est);
                chk("R10", $sformatf("vector %0d sleep_clr", i), {31'd0, sleep_clr}, 32'd1);
                chk("R9", $sformatf("vector %0d new_irq_sp", i), new_irq_sp, eisp);
                chk("R9", $sformatf("vector %0d new_r0", i), new_r0, eisp);
                chk("R9", $sformatf("vector %0d new_usr_sp", i), new_usr_sp, eusp);
                if (v.ek == 2'd2) begin
                    chk("R5", $sformatf("vector %0d memory accesses", i), 32'(log_n), 32'd0);
                    chk("R5", $sformatf("vector %0d save_we", i), {31'd0, save_we}, 32'd1);
                    chk("R5", $sformatf("vector %0d save_pc", i), save_pc, pc_i);
                    chk("R5", $sformatf("vector %0d save_stat", i), save_stat, v.st);
                end else begin
                    chk("R6", $sformatf("vector %0d memory accesses", i), 32'(log_n), 32'd3);
                    chk("R6", $sformatf("vector %0d save_we", i), {31'd0, save_we}, 32'd0);
                    chk("R6", "first push", {log_a[0][31:1], log_w[0]}, {(base - 32'd4) >> 1, 1'b1});
                    chk("R6", "first push data", log_d[0], v.st);
                    chk("R6", "second push", {log_a[1][31:1], log_w[1]}, {(base - 32'd8) >> 1, 1'b1});
                    chk("R6", "second push data", log_d[1], pc_i);
                    chk("R8", "vector read", {log_a[2][31:1], log_w[2]}, {vad >> 1, 1'b0});
                end
                chk("R11", $sformatf("vector %0d ack", i), {30'd0, ack_valid, ack_fast},
                    (v.ek == 2'd1) ? 32'd0 : ((v.ek == 2'd2) ? 32'd3 : 32'd2));
                if (v.ek != 2'd1)
                    chk("R11", $sformatf("vector %0d ack_num", i), {24'd0, ack_num},
                        (v.ek == 2'd3) ? {24'd0, v.nv} : 32'd0);
            end
            exc_req = 0; fst_req = 0; nrm_req = 0;
            @(negedge clk);
        end

        // R4: qualifying request without a boundary is not sampled
        cur_stat = 32'h0001_0000; nrm_req = 1; nrm_vec = 8'h12; nrm_lvl = 4'd6;
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                seen = seen | busy;
            end
            chk("R4", "no entry without boundary", {31'd0, seen}, 32'd0);
        end

        // R4: changes during an entry do not alter it
        cur_lat = 3; log_n = 0; cur_r0 = 32'h0000_9000; cur_pc = 32'h0000_4444;
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0;
        @(negedge clk);
        nrm_vec = 8'h34; nrm_lvl = 4'd9; fst_req = 1; exc_req = 1; exc_code = 9'h015;
        insn_boundary = 1'b1;
        repeat (2) @(negedge clk);
        insn_boundary = 1'b0; fst_req = 0; exc_req = 0;
        wait_done("R4");
        chk("R4", "latched vector", {24'd0, ack_num}, 32'h12);
        chk("R4", "latched level", {28'd0, new_stat[27:24]}, 32'd6);
        chk("R4", "no fast override", {31'd0, ack_fast}, 32'd0);
        chk("R7", "latched handler", new_pc, mem_model(TB_BASE + 32'h48));
        nrm_req = 0;
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                seen = seen | busy;
            end
            chk("R4", "no second entry", {31'd0, seen}, 32'd0);
        end

        // R13: reset during a stacked entry returns to idle
        cur_lat = 2; exc_req = 1; exc_code = 9'h01E;
        insn_boundary = 1'b1;
        @(negedge clk);
        insn_boundary = 1'b0; exc_req = 0;
        @(negedge clk);
        chk("R12", "busy during entry", {31'd0, busy}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R13", "busy after mid-entry reset", {31'd0, busy}, 32'd0);
        chk("R13", "mem_valid after mid-entry reset", {31'd0, mem_valid}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13", "idle after reset release", {30'd0, busy, done}, 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule